// File: doc/BRIEF.md
# Carry-Save Reduction Tree for Eight Booth Partial Products

This block takes eight Booth-recoded partial products, each one bit wider than the coefficient, together with the eight carry-in bits that the Booth decoders produce for negative multiples. It reduces them to a redundant result: one sum vector, one carry vector and two carry-in bits that are still pending. The reduction uses only 3:2 compressors (full adders). Each carry-in is absorbed into the empty bit 0 of a carry vector after that vector's one-position left shift, so no separate carry-in adder tree and no half adders are needed. Six compressor rows create six carry vectors, so six carry-ins are absorbed and the last two are passed out for a downstream accumulator to fold into its own free carry slots.

Four compressor layers do the work. Layer one compresses products 0-2 and products 3-5. Layer two combines the first layer's results with products 6 and 7. Layers three and four bring everything down to one sum and carry pair. A parameter places registers after every second layer, after every layer, or nowhere. A valid strobe travels through the same registers, so it stays aligned with the data.

Top module: `csa_carry_tree`

## Requirements
- R1: For every accepted beat, sum_vec + carry_vec + cin_left[0] + cin_left[1], taken modulo 2^(L+4), equals the sum of the eight partial products (each read as an unsigned L+1-bit field, product k at bits [k*(L+1) +: L+1] of pp) plus the count of set bits in cin. This must hold for every compressor layer as well.
- R2: cin_left[1:0] carries cin[7:6] of the same beat, unchanged.
- R3: Bit 0 of carry_vec carries cin[5] of the same beat.
- R4: out_valid repeats in_valid after a fixed latency: 0 cycles for PIPE=0 (no registers), 2 cycles for PIPE=1 (registers after layers 2 and 4, the default), and 4 cycles for PIPE=2 (registers after every layer).
- R5: While rst_n is low, a pipelined configuration drives out_valid, sum_vec, carry_vec and cin_left to zero.
- R6: When every partial product and every carry-in is zero, sum_vec, carry_vec and cin_left are all zero.
- R7: A single carry-in bit set on its own, with all products zero, adds exactly one to the reconstructed total, whichever of the eight positions it occupies.
- R8: When all products are all-ones and all eight carry-ins are set, the total is 8*2^(L+1), and the reconstructed result wraps to zero.
- R9: With in_valid high every cycle, each output beat matches its own input beat. The block accepts one beat per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional pipeline registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies pp and cin this cycle |
| pp | input | 8*(L+1) | Eight partial products, product k in bits [k*(L+1) +: L+1] |
| cin | input | 8 | Booth carry-in bits, bit k belongs to product k |
| out_valid | output | 1 | in_valid delayed by the pipeline latency |
| sum_vec | output | L+4 | Redundant result, sum half |
| carry_vec | output | L+4 | Redundant result, carry half, bit 0 holds cin[5] |
| cin_left | output | 2 | Carry-ins not absorbed (cin[7:6]) |

## Verification
The tree is driven with several kinds of products: ascending small values, values large enough to carry through many columns, alternating 0x555/0x2AA bit patterns, and a single full-scale product. These show whether carries move correctly across columns and into the widened upper bits. Carry-in bits are tested one at a time with all products zero, so that a carry-in routed to the wrong slot, dropped, or counted twice shows up as a total other than one. A sweep of all-ones inputs checks the modular wrap. A back-to-back stream and a single valid pulse distinguish correct pipeline alignment from beats that slip or arrive out of order.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

  typedef enum logic [1:0] {
    PIPE_NONE      = 2'd0,
    PIPE_EVERY_TWO = 2'd1,
    PIPE_EVERY_ONE = 2'd2
  } pipe_mode_e;

  // Whether a register bank follows compressor layer 'layer' (1..4).
  function automatic bit reg_after_layer(pipe_mode_e mode, int layer);
    case (mode)
      PIPE_EVERY_ONE: return 1'b1;
      PIPE_EVERY_TWO: return (layer == 2) || (layer == 4);
      default:        return 1'b0;
    endcase
  endfunction

  function automatic int stage_latency(pipe_mode_e mode);
    int n;
    n = 0;
    for (int k = 1; k <= 4; k++) n += int'(reg_after_layer(mode, k));
    return n;
  endfunction

endpackage

// File: rtl/csa32_row.sv
// One row of 3:2 compressors. The carry output is shifted left by one,
// and the freed bit 0 takes a Booth carry-in.
module csa32_row #(
  parameter int W = 14
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic         ci_slot,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);
  logic [W-1:0] maj;

  assign s   = a ^ b ^ c;
  assign maj = (a & b) | (a & c) | (b & c);
  assign cy  = {maj[W-2:0], ci_slot};
endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/csa_carry_tree.sv
module csa_carry_tree
  import csa_tree_pkg::*;
#(
  parameter int         L    = 10,
  parameter pipe_mode_e PIPE = PIPE_EVERY_TWO
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [8*(L+1)-1:0]   pp,
  input  logic [7:0]           cin,
  output logic                 out_valid,
  output logic [L+3:0]         sum_vec,
  output logic [L+3:0]         carry_vec,
  output logic [1:0]           cin_left
);
  localparam int PW   = L + 1;
  localparam int OW   = PW + 3;
  localparam int LAT  = stage_latency(PIPE);
  localparam bit REG1 = reg_after_layer(PIPE, 1);
  localparam bit REG2 = reg_after_layer(PIPE, 2);
  localparam bit REG3 = reg_after_layer(PIPE, 3);
  localparam bit REG4 = reg_after_layer(PIPE, 4);
  localparam int B1W  = 6*OW + 6 + 1;
  localparam int B2W  = 4*OW + 4 + 1;
  localparam int B3W  = 3*OW + 3 + 1;
  localparam int B4W  = 2*OW + 2 + 1;

  // Zero-extended partial products
  logic [7:0][OW-1:0] pe;
  for (genvar k = 0; k < 8; k++) begin : g_ext
    assign pe[k] = OW'(pp[k*PW +: PW]);
  end

  // ---------------- Layer 1 ----------------
  logic [OW-1:0] l1_s00, l1_c00, l1_s01, l1_c01;
  csa32_row #(.W(OW)) u_l1a (.a(pe[0]), .b(pe[1]), .c(pe[2]), .ci_slot(cin[0]),
                             .s(l1_s00), .cy(l1_c00));
  csa32_row #(.W(OW)) u_l1b (.a(pe[3]), .b(pe[4]), .c(pe[5]), .ci_slot(cin[1]),
                             .s(l1_s01), .cy(l1_c01));

  logic [B1W-1:0] b1_d, b1_q;
  assign b1_d = {l1_s00, l1_c00, l1_s01, l1_c01, pe[6], pe[7], cin[7:2], in_valid};
  if (REG1) begin : g_r1
    stage_reg #(.W(B1W)) u_r (.clk(clk), .rst_n(rst_n), .d(b1_d), .q(b1_q));
  end else begin : g_w1
    assign b1_q = b1_d;
  end

  logic [OW-1:0] r1_s00, r1_c00, r1_s01, r1_c01, r1_p6, r1_p7;
  logic [7:2]    r1_ci;
  logic          r1_v;
  assign {r1_s00, r1_c00, r1_s01, r1_c01, r1_p6, r1_p7, r1_ci, r1_v} = b1_q;

  // ---------------- Layer 2 ----------------
  logic [OW-1:0] l2_s10, l2_c10, l2_s11, l2_c11;
  csa32_row #(.W(OW)) u_l2a (.a(r1_s00), .b(r1_c00), .c(r1_s01), .ci_slot(r1_ci[2]),
                             .s(l2_s10), .cy(l2_c10));
  csa32_row #(.W(OW)) u_l2b (.a(r1_c01), .b(r1_p6), .c(r1_p7), .ci_slot(r1_ci[3]),
                             .s(l2_s11), .cy(l2_c11));

  logic [B2W-1:0] b2_d, b2_q;
  assign b2_d = {l2_s10, l2_c10, l2_s11, l2_c11, r1_ci[7:4], r1_v};
  if (REG2) begin : g_r2
    stage_reg #(.W(B2W)) u_r (.clk(clk), .rst_n(rst_n), .d(b2_d), .q(b2_q));
  end else begin : g_w2
    assign b2_q = b2_d;
  end

  logic [OW-1:0] r2_s10, r2_c10, r2_s11, r2_c11;
  logic [7:4]    r2_ci;
  logic          r2_v;
  assign {r2_s10, r2_c10, r2_s11, r2_c11, r2_ci, r2_v} = b2_q;

  // ---------------- Layer 3 ----------------
  logic [OW-1:0] l3_s2, l3_c2;
  csa32_row #(.W(OW)) u_l3 (.a(r2_s10), .b(r2_c10), .c(r2_s11), .ci_slot(r2_ci[4]),
                            .s(l3_s2), .cy(l3_c2));

  logic [B3W-1:0] b3_d, b3_q;
  assign b3_d = {l3_s2, l3_c2, r2_c11, r2_ci[7:5], r2_v};
  if (REG3) begin : g_r3
    stage_reg #(.W(B3W)) u_r (.clk(clk), .rst_n(rst_n), .d(b3_d), .q(b3_q));
  end else begin : g_w3
    assign b3_q = b3_d;
  end

  logic [OW-1:0] r3_s2, r3_c2, r3_c11;
  logic [7:5]    r3_ci;
  logic          r3_v;
  assign {r3_s2, r3_c2, r3_c11, r3_ci, r3_v} = b3_q;

  // ---------------- Layer 4 ----------------
  logic [OW-1:0] l4_s3, l4_c3;
  csa32_row #(.W(OW)) u_l4 (.a(r3_s2), .b(r3_c2), .c(r3_c11), .ci_slot(r3_ci[5]),
                            .s(l4_s3), .cy(l4_c3));

  logic [B4W-1:0] b4_d, b4_q;
  assign b4_d = {l4_s3, l4_c3, r3_ci[7:6], r3_v};
  if (REG4) begin : g_r4
    stage_reg #(.W(B4W)) u_r (.clk(clk), .rst_n(rst_n), .d(b4_d), .q(b4_q));
  end else begin : g_w4
    assign b4_q = b4_d;
  end

  assign {sum_vec, carry_vec, cin_left, out_valid} = b4_q;

endmodule

// File: rtl/csa_carry_tree_chk.sv
module csa_carry_tree_chk #(
  parameter int OW  = 14,
  parameter int LAT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               out_valid,
  input logic [7:0][OW-1:0] pe,
  input logic [7:0]         cin,
  input logic [OW-1:0]      l1_s00, l1_c00, l1_s01, l1_c01,
  input logic [OW-1:0]      r1_s00, r1_c00, r1_s01, r1_c01, r1_p6, r1_p7,
  input logic [7:2]         r1_ci,
  input logic [OW-1:0]      l2_s10, l2_c10, l2_s11, l2_c11,
  input logic [OW-1:0]      r2_s10, r2_c10, r2_s11,
  input logic [7:4]         r2_ci,
  input logic [OW-1:0]      l3_s2, l3_c2,
  input logic [OW-1:0]      r3_s2, r3_c2, r3_c11,
  input logic [7:5]         r3_ci,
  input logic [OW-1:0]      l4_s3, l4_c3
);
  logic [OW-1:0] in1, out1, in2, out2, in3, out3, in4, out4;

  always_comb begin
    in1  = pe[0] + pe[1] + pe[2] + pe[3] + pe[4] + pe[5]
         + OW'(cin[0]) + OW'(cin[1]);
    out1 = l1_s00 + l1_c00 + l1_s01 + l1_c01;
    in2  = r1_s00 + r1_c00 + r1_s01 + r1_c01 + r1_p6 + r1_p7
         + OW'(r1_ci[2]) + OW'(r1_ci[3]);
    out2 = l2_s10 + l2_c10 + l2_s11 + l2_c11;
    in3  = r2_s10 + r2_c10 + r2_s11 + OW'(r2_ci[4]);
    out3 = l3_s2 + l3_c2;
    in4  = r3_s2 + r3_c2 + r3_c11 + OW'(r3_ci[5]);
    out4 = l4_s3 + l4_c3;
  end

  assert_layer1_conserve_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out1 == in1);
  assert_layer2_conserve_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out2 == in2);
  assert_layer3_conserve_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out3 == in3);
  assert_layer4_conserve_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out4 == in4);

  // Valid history kept by the checker, reset like the pipeline
  logic [4:0] vh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vh <= '0;
    else        vh <= {vh[3:0], in_valid};
  end

  if (LAT == 0) begin : g_lat0
    assert_valid_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
  end else begin : g_latn
    assert_valid_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vh[LAT-1]);
  end
endmodule

bind csa_carry_tree csa_carry_tree_chk #(.OW(OW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .pe(pe), .cin(cin),
  .l1_s00(l1_s00), .l1_c00(l1_c00), .l1_s01(l1_s01), .l1_c01(l1_c01),
  .r1_s00(r1_s00), .r1_c00(r1_c00), .r1_s01(r1_s01), .r1_c01(r1_c01),
  .r1_p6(r1_p6), .r1_p7(r1_p7), .r1_ci(r1_ci),
  .l2_s10(l2_s10), .l2_c10(l2_c10), .l2_s11(l2_s11), .l2_c11(l2_c11),
  .r2_s10(r2_s10), .r2_c10(r2_c10), .r2_s11(r2_s11), .r2_ci(r2_ci),
  .l3_s2(l3_s2), .l3_c2(l3_c2),
  .r3_s2(r3_s2), .r3_c2(r3_c2), .r3_c11(r3_c11), .r3_ci(r3_ci),
  .l4_s3(l4_s3), .l4_c3(l4_c3)
);

// File: tb/tb_csa_carry_tree.sv
module tb_csa_carry_tree;
  localparam int L   = 10;
  localparam int PW  = L + 1;
  localparam int OW  = PW + 3;
  localparam int LAT = 2;          // default mode, per R4
  localparam int NV  = 8;
  localparam int VW  = 8*PW + 8 + OW;

  // {p7..p0, cin, expected total mod 2^OW}
  localparam logic [VW-1:0] VEC [NV] = '{
    {11'd8, 11'd7, 11'd6, 11'd5, 11'd4, 11'd3, 11'd2, 11'd1, 8'h00, 14'd36},
    {11'd2047, 11'd2047, 11'd2047, 11'd2047, 11'd2047, 11'd2047, 11'd2047, 11'd2047,
     8'hFF, 14'd0},
    {11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 8'h01, 14'd1},
    {11'd800, 11'd700, 11'd600, 11'd500, 11'd400, 11'd300, 11'd200, 11'd100,
     8'h0F, 14'd3604},
    {11'd1024, 11'd1024, 11'd1024, 11'd1024, 11'd1024, 11'd1024, 11'd1024, 11'd1024,
     8'h80, 14'd8193},
    {11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd2047, 8'hF0, 14'd2051},
    {11'd682, 11'd1365, 11'd682, 11'd1365, 11'd682, 11'd1365, 11'd682, 11'd1365,
     8'hAA, 14'd8192},
    {11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 8'h00, 14'd0}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [8*PW-1:0] pp = '0;
  logic [7:0]      cin = '0;
  logic            out_valid;
  logic [OW-1:0]   sum_vec, carry_vec;
  logic [1:0]      cin_left;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  csa_carry_tree #(.L(L)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pp(pp), .cin(cin),
    .out_valid(out_valid), .sum_vec(sum_vec), .carry_vec(carry_vec),
    .cin_left(cin_left));

  function automatic logic [OW-1:0] recon();
    return sum_vec + carry_vec + OW'(cin_left[0]) + OW'(cin_left[1]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R5: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R5", "out_valid in reset", out_valid, 0);
    chk(sum_vec == '0 && carry_vec == '0, "R5", "data in reset", sum_vec | carry_vec, 0);
    chk(cin_left == 2'b00, "R5", "cin_left in reset", cin_left, 0);
    rst_n = 1'b1;

    // Table walk, one beat at a time: R1, R2, R3, R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pp = VEC[i][VW-1 -: 8*PW];
      cin = VEC[i][OW +: 8];
      in_valid = 1'b1;
      repeat (LAT) @(negedge clk);
      #1;
      chk(out_valid, "R4", "out_valid on table beat", out_valid, 1);
      chk(recon() == VEC[i][OW-1:0], (i == 1) ? "R8" : "R1", "reconstructed total",
          recon(), VEC[i][OW-1:0]);
      chk(cin_left == cin[7:6], "R2", "leftover carry-ins", cin_left, cin[7:6]);
      chk(carry_vec[0] == cin[5], "R3", "carry_vec bit0", carry_vec[0], cin[5]);
      if (i == NV-1)
        chk(sum_vec == '0 && carry_vec == '0 && cin_left == '0, "R6",
            "all-zero input", sum_vec | carry_vec, 0);
    end

    // R7: each carry-in alone is worth exactly one
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      pp = '0;
      cin = 8'(1 << k);
      in_valid = 1'b1;
      repeat (LAT) @(negedge clk);
      #1;
      chk(recon() == OW'(1), "R7", $sformatf("single carry-in %0d", k), recon(), 1);
    end

    // R4: single valid pulse appears exactly LAT cycles later
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT + 1) @(negedge clk);
    in_valid = 1'b1;
    for (int c = 0; c <= LAT + 1; c++) begin
      #1;
      chk(out_valid == (c == LAT), "R4", $sformatf("pulse cycle %0d", c),
          out_valid, (c == LAT));
      @(negedge clk);
      in_valid = 1'b0;
    end

    // R9: back-to-back stream
    for (int k = 0; k < NV + LAT; k++) begin
      if (k < NV) begin
        pp = VEC[k][VW-1 -: 8*PW];
        cin = VEC[k][OW +: 8];
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (k >= LAT) begin
        chk(out_valid, "R9", "stream valid", out_valid, 1);
        chk(recon() == VEC[k-LAT][OW-1:0], "R9", $sformatf("stream beat %0d", k-LAT),
            recon(), VEC[k-LAT][OW-1:0]);
        chk(cin_left == VEC[k-LAT][OW+6 +: 2], "R9", "stream leftover",
            cin_left, VEC[k-LAT][OW+6 +: 2]);
      end
      @(negedge clk);
    end

    finish_run();
  end
endmodule